// File: doc/BRIEF.md
# Window Overlap Coordinate Generator

This block walks the target image of a scaler in raster order and produces one result per clock. Each result names the target pixel, the top-left source pixel that its window touches, and how the window splits between the two source columns and the two source rows it can straddle. All extents are in grid units, where one grid is a fixed fraction of a target pixel. The multiply-heavy overlap geometry becomes running sums. A window displacement grows by the window size for each target step. A source edge register grows by the rounded source-pixel size whenever the window passes it.

Rounding the source-pixel size to whole grids makes the window walk drift from the true geometry. A caller-supplied regulation plan cancels this drift. Every `step` target pixels, up to `num` times per row (or per frame vertically), the window is moved by one extra grid. The move is left (overlapping) when the rounding went down and right (inserting) when it went up. The downstream area and weighting logic consumes the four extents.

Top module: `ovl_coord_gen`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first start, `valid_o` is 0.
- R2: The edge that samples `start_i` high begins a frame. Results then appear on `valid_o`, starting one cycle after that edge, for exactly `tgt_w_i * tgt_h_i` consecutive cycles. `tgt_x_o` counts 0..W-1 and then wraps to 0 while `tgt_y_o` increments. After the last pixel, `valid_o` returns to 0.
- R3: With horizontal displacement d = x*win_w + cx(x) and source index s, the left extent `ovl_l_o` equals min((s+1)*src_w - d, win_w). The right extent `ovl_r_o` equals win_w minus the left extent.
- R4: The top and bottom extents follow the R3 rule vertically, using d = y*win_h + cy(y), the window height and the source height.
- R5: `src_x_o` equals floor(d / src_w) and `src_y_o` equals floor(d / src_h). Within a row the source column can advance by 0, 1 or 2 per target step.
- R6: The horizontal correction cx(x) is min(num_x, floor(x/step_x)). It is negated when `reg_dn_x_i` is 1 (shift left) and positive when it is 0. It is 0 when step_x or num_x is 0. The correction restarts at every row.
- R7: The vertical correction cy(y) follows the R6 rule using the row index and the vertical regulation inputs.
- R8: All configuration inputs are captured on the start edge. Changing them during a frame has no effect on that frame's results.
- R9: A start during a running frame abandons it. The result after the restart edge is pixel (0,0) of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe; samples configuration |
| tgt_w_i | input | CW | Target width in pixels (>= 1) |
| tgt_h_i | input | CW | Target height in pixels (>= 1) |
| win_w_i | input | WW | Window width in grids |
| win_h_i | input | WW | Window height in grids |
| src_w_i | input | SW | Rounded source-pixel width in grids |
| src_h_i | input | SW | Rounded source-pixel height in grids |
| reg_step_x_i | input | CW | Target pixels between horizontal regulations |
| reg_num_x_i | input | CW | Horizontal regulations per row |
| reg_dn_x_i | input | 1 | 1: shift left by one grid, 0: shift right |
| reg_step_y_i | input | CW | Rows between vertical regulations |
| reg_num_y_i | input | CW | Vertical regulations per frame |
| reg_dn_y_i | input | 1 | 1: shift up by one grid, 0: shift down |
| valid_o | output | 1 | Result valid |
| tgt_x_o | output | CW | Target column |
| tgt_y_o | output | CW | Target row |
| src_x_o | output | CW | Top-left source column overlapped |
| src_y_o | output | CW | Top-left source row overlapped |
| ovl_l_o | output | WW | Window extent inside the left source column |
| ovl_r_o | output | WW | Window extent inside the right source column |
| ovl_t_o | output | WW | Window extent inside the upper source row |
| ovl_b_o | output | WW | Window extent inside the lower source row |

## Verification
Some structural invariants are checked on every cycle:
- the left/right and top/bottom extents sum to the captured window size;
- the left extent is never zero;
- the raster counters step and wrap correctly;
- the source column never retreats or jumps by more than two inside a row.

Other behaviour only shows up against an independent arithmetic model over whole frames:
- the exact values of the extents and source indices;
- where each regulation lands, and in which direction;
- that mid-frame configuration changes are ignored;
- what a restart truncates.

// File: rtl/ovl_coord_pkg.sv
package ovl_coord_pkg;
  localparam int unsigned AXES = 2;
  localparam int unsigned AX_H = 0;
  localparam int unsigned AX_V = 1;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INIT = 2'd1,
    STEP_NEXT = 2'd2
  } step_e;
endpackage

// File: rtl/ovl_axis_walker.sv
module ovl_axis_walker
  import ovl_coord_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned WW = 6,
  parameter int unsigned SW = 8,
  parameter int unsigned DW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  step_e         op_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [WW-1:0] win_i,
  input  logic [SW-1:0] src_i,
  input  logic [CW-1:0] reg_step_i,
  input  logic [CW-1:0] reg_num_i,
  input  logic          reg_dn_i,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] src_idx_o,
  output logic [DW-1:0] disp_o,
  output logic [DW-1:0] edge_o,
  output logic          last_o
);
  logic [CW-1:0] idx_q, sidx_q, rcnt_q, rapp_q;
  logic [DW-1:0] disp_q, edge_q;
  logic          reg_hit, rcnt_wrap;
  logic [DW-1:0] src_w, edge_one, edge_two, disp_nx, edge_nx;
  logic [CW-1:0] sidx_nx;

  assign src_w     = DW'(src_i);
  assign rcnt_wrap = (rcnt_q == reg_step_i - CW'(1));
  assign reg_hit   = (reg_step_i != '0) && (rapp_q < reg_num_i) && rcnt_wrap;

  always_comb begin
    disp_nx = disp_q + DW'(win_i);
    if (reg_hit) begin
      if (reg_dn_i) disp_nx = disp_nx - DW'(1);
      else          disp_nx = disp_nx + DW'(1);
    end
  end

  // window may cross up to two source edges in one step
  assign edge_one = edge_q;
  assign edge_two = edge_q + src_w;
  always_comb begin
    sidx_nx = sidx_q;
    edge_nx = edge_q;
    if (disp_nx >= edge_two) begin
      sidx_nx = sidx_q + CW'(2);
      edge_nx = edge_two + src_w;
    end else if (disp_nx >= edge_one) begin
      sidx_nx = sidx_q + CW'(1);
      edge_nx = edge_two;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sidx_q <= '0;
      rcnt_q <= '0;
      rapp_q <= '0;
      disp_q <= '0;
      edge_q <= '0;
    end else begin
      unique case (op_i)
        STEP_INIT: begin
          idx_q  <= '0;
          sidx_q <= '0;
          rcnt_q <= '0;
          rapp_q <= '0;
          disp_q <= '0;
          edge_q <= src_w;
        end
        STEP_NEXT: begin
          idx_q  <= idx_q + CW'(1);
          sidx_q <= sidx_nx;
          disp_q <= disp_nx;
          edge_q <= edge_nx;
          rcnt_q <= rcnt_wrap ? '0 : rcnt_q + CW'(1);
          if (reg_hit) rapp_q <= rapp_q + CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign idx_o     = idx_q;
  assign src_idx_o = sidx_q;
  assign disp_o    = disp_q;
  assign edge_o    = edge_q;
  assign last_o    = (idx_q == cnt_i - CW'(1));
endmodule

// File: rtl/ovl_span_split.sv
module ovl_span_split #(
  parameter int unsigned WW = 6,
  parameter int unsigned DW = 21
) (
  input  logic [DW-1:0] disp_i,
  input  logic [DW-1:0] edge_i,
  input  logic [WW-1:0] win_i,
  output logic [WW-1:0] near_o,
  output logic [WW-1:0] far_o
);
  logic [DW-1:0] gap;

  assign gap    = edge_i - disp_i;
  assign near_o = (gap < DW'(win_i)) ? gap[WW-1:0] : win_i;
  assign far_o  = win_i - near_o;
endmodule

// File: rtl/ovl_coord_gen.sv
module ovl_coord_gen
  import ovl_coord_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned WW = 6,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] tgt_w_i,
  input  logic [CW-1:0] tgt_h_i,
  input  logic [WW-1:0] win_w_i,
  input  logic [WW-1:0] win_h_i,
  input  logic [SW-1:0] src_w_i,
  input  logic [SW-1:0] src_h_i,
  input  logic [CW-1:0] reg_step_x_i,
  input  logic [CW-1:0] reg_num_x_i,
  input  logic          reg_dn_x_i,
  input  logic [CW-1:0] reg_step_y_i,
  input  logic [CW-1:0] reg_num_y_i,
  input  logic          reg_dn_y_i,
  output logic          valid_o,
  output logic [CW-1:0] tgt_x_o,
  output logic [CW-1:0] tgt_y_o,
  output logic [CW-1:0] src_x_o,
  output logic [CW-1:0] src_y_o,
  output logic [WW-1:0] ovl_l_o,
  output logic [WW-1:0] ovl_r_o,
  output logic [WW-1:0] ovl_t_o,
  output logic [WW-1:0] ovl_b_o
);
  localparam int unsigned DW = CW + SW + 1;

  logic [AXES-1:0][CW-1:0] cnt_in,  cnt_q,  cnt_use;
  logic [AXES-1:0][WW-1:0] win_in,  win_q,  win_use;
  logic [AXES-1:0][SW-1:0] src_in,  src_q,  src_use;
  logic [AXES-1:0][CW-1:0] stp_in,  stp_q,  stp_use;
  logic [AXES-1:0][CW-1:0] num_in,  num_q,  num_use;
  logic [AXES-1:0]         dn_in,   dn_q,   dn_use;

  step_e                   op     [AXES];
  logic [AXES-1:0][CW-1:0] idx, sidx;
  logic [AXES-1:0][DW-1:0] disp, edge_pos;
  logic [AXES-1:0]         last;
  logic [AXES-1:0][WW-1:0] near, far;

  logic run_q, run_d;

  assign cnt_in = {tgt_h_i, tgt_w_i};
  assign win_in = {win_h_i, win_w_i};
  assign src_in = {src_h_i, src_w_i};
  assign stp_in = {reg_step_y_i, reg_step_x_i};
  assign num_in = {reg_num_y_i, reg_num_x_i};
  assign dn_in  = {reg_dn_y_i, reg_dn_x_i};

  // stage 0/1: configuration capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= '0;
      src_q <= '0;
      stp_q <= '0;
      num_q <= '0;
      dn_q  <= '0;
    end else if (start_i) begin
      cnt_q <= cnt_in;
      win_q <= win_in;
      src_q <= src_in;
      stp_q <= stp_in;
      num_q <= num_in;
      dn_q  <= dn_in;
    end
  end

  assign cnt_use = start_i ? cnt_in : cnt_q;
  assign win_use = start_i ? win_in : win_q;
  assign src_use = start_i ? src_in : src_q;
  assign stp_use = start_i ? stp_in : stp_q;
  assign num_use = start_i ? num_in : num_q;
  assign dn_use  = start_i ? dn_in  : dn_q;

  // raster sequencing
  always_comb begin
    op[AX_H] = STEP_HOLD;
    op[AX_V] = STEP_HOLD;
    run_d    = run_q;
    if (start_i) begin
      op[AX_H] = STEP_INIT;
      op[AX_V] = STEP_INIT;
      run_d    = 1'b1;
    end else if (run_q) begin
      if (!last[AX_H]) begin
        op[AX_H] = STEP_NEXT;
      end else if (!last[AX_V]) begin
        op[AX_H] = STEP_INIT;
        op[AX_V] = STEP_NEXT;
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    ovl_axis_walker #(.CW(CW), .WW(WW), .SW(SW), .DW(DW)) u_walk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_i       (op[a]),
      .cnt_i      (cnt_use[a]),
      .win_i      (win_use[a]),
      .src_i      (src_use[a]),
      .reg_step_i (stp_use[a]),
      .reg_num_i  (num_use[a]),
      .reg_dn_i   (dn_use[a]),
      .idx_o      (idx[a]),
      .src_idx_o  (sidx[a]),
      .disp_o     (disp[a]),
      .edge_o     (edge_pos[a]),
      .last_o     (last[a])
    );

    ovl_span_split #(.WW(WW), .DW(DW)) u_split (
      .disp_i (disp[a]),
      .edge_i (edge_pos[a]),
      .win_i  (win_q[a]),
      .near_o (near[a]),
      .far_o  (far[a])
    );
  end

  // stage 2: extents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tgt_x_o <= '0;
      tgt_y_o <= '0;
      src_x_o <= '0;
      src_y_o <= '0;
      ovl_l_o <= '0;
      ovl_r_o <= '0;
      ovl_t_o <= '0;
      ovl_b_o <= '0;
    end else begin
      valid_o <= run_q;
      tgt_x_o <= idx[AX_H];
      tgt_y_o <= idx[AX_V];
      src_x_o <= sidx[AX_H];
      src_y_o <= sidx[AX_V];
      ovl_l_o <= near[AX_H];
      ovl_r_o <= far[AX_H];
      ovl_t_o <= near[AX_V];
      ovl_b_o <= far[AX_V];
    end
  end
endmodule

// File: rtl/ovl_coord_gen_chk.sv
module ovl_coord_gen_chk #(
  parameter int unsigned CW = 12,
  parameter int unsigned WW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          valid_o,
  input logic [CW-1:0] tgt_x_o,
  input logic [CW-1:0] tgt_y_o,
  input logic [CW-1:0] src_x_o,
  input logic [WW-1:0] ovl_l_o,
  input logic [WW-1:0] ovl_r_o,
  input logic [WW-1:0] ovl_t_o,
  input logic [WW-1:0] ovl_b_o,
  input logic [WW-1:0] win_w_q,
  input logic [WW-1:0] win_h_q
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) idle_in_reset_chk: assert (!valid_o);
  end

  // R2
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && !$past(start_i, 2) && tgt_x_o != '0
    |-> tgt_x_o == $past(tgt_x_o) + CW'(1) && tgt_y_o == $past(tgt_y_o));

  // R2
  row_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && !$past(start_i, 2) && tgt_x_o == '0
    |-> tgt_y_o == $past(tgt_y_o) + CW'(1));

  // R3
  lr_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !$past(start_i)
    |-> (WW+1)'(ovl_l_o) + (WW+1)'(ovl_r_o) == (WW+1)'(win_w_q));

  // R3
  left_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !$past(start_i) |-> ovl_l_o != '0 && ovl_l_o <= win_w_q);

  // R4
  tb_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !$past(start_i)
    |-> (WW+1)'(ovl_t_o) + (WW+1)'(ovl_b_o) == (WW+1)'(win_h_q));

  // R5
  src_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && !$past(start_i, 2) && tgt_x_o != '0
    |-> src_x_o >= $past(src_x_o) && src_x_o <= $past(src_x_o) + CW'(2));
endmodule

bind ovl_coord_gen ovl_coord_gen_chk #(.CW(CW), .WW(WW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_o (valid_o),
  .tgt_x_o (tgt_x_o),
  .tgt_y_o (tgt_y_o),
  .src_x_o (src_x_o),
  .ovl_l_o (ovl_l_o),
  .ovl_r_o (ovl_r_o),
  .ovl_t_o (ovl_t_o),
  .ovl_b_o (ovl_b_o),
  .win_w_q (win_q[0]),
  .win_h_q (win_q[1])
);

// File: tb/ovl_coord_gen_bench.sv
module ovl_coord_gen_bench;
  localparam int CW = 12;
  localparam int WW = 6;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          start_i = 1'b0;
  logic [CW-1:0] tgt_w_i = '0, tgt_h_i = '0;
  logic [WW-1:0] win_w_i = '0, win_h_i = '0;
  logic [SW-1:0] src_w_i = '0, src_h_i = '0;
  logic [CW-1:0] reg_step_x_i = '0, reg_num_x_i = '0, reg_step_y_i = '0, reg_num_y_i = '0;
  logic          reg_dn_x_i = 1'b0, reg_dn_y_i = 1'b0;
  logic          valid_o;
  logic [CW-1:0] tgt_x_o, tgt_y_o, src_x_o, src_y_o;
  logic [WW-1:0] ovl_l_o, ovl_r_o, ovl_t_o, ovl_b_o;

  ovl_coord_gen #(.CW(CW), .WW(WW), .SW(SW)) u_ovl_coord_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .tgt_w_i(tgt_w_i), .tgt_h_i(tgt_h_i), .win_w_i(win_w_i), .win_h_i(win_h_i),
    .src_w_i(src_w_i), .src_h_i(src_h_i),
    .reg_step_x_i(reg_step_x_i), .reg_num_x_i(reg_num_x_i), .reg_dn_x_i(reg_dn_x_i),
    .reg_step_y_i(reg_step_y_i), .reg_num_y_i(reg_num_y_i), .reg_dn_y_i(reg_dn_y_i),
    .valid_o(valid_o), .tgt_x_o(tgt_x_o), .tgt_y_o(tgt_y_o),
    .src_x_o(src_x_o), .src_y_o(src_y_o),
    .ovl_l_o(ovl_l_o), .ovl_r_o(ovl_r_o), .ovl_t_o(ovl_t_o), .ovl_b_o(ovl_b_o)
  );

  typedef struct {
    int x, y, sx, sy, l, r, t, b;
    string tag;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // scenario configuration
  int cw, ch, ww, wh, sw, sh, stx, nx, dx, sty, ny, dy;

  function automatic int corr(int i, int step, int num, int dn);
    int c;
    if (step == 0 || num == 0) return 0;
    c = i / step;
    if (c > num) c = num;
    return dn ? -c : c;
  endfunction

  function automatic void ext(int i, int win, int src, int step, int num, int dn,
                              output int s, output int nr, output int fr);
    int d, e;
    d  = i * win + corr(i, step, num, dn);
    s  = d / src;
    e  = (s + 1) * src;
    nr = (e - d < win) ? e - d : win;
    fr = win - nr;
  endfunction

  task automatic push_frame(int npix, string tag);
    int n = 0;
    for (int l = 0; l < ch; l++) begin
      for (int k = 0; k < cw; k++) begin
        exp_t e;
        if (n < npix) begin
          e.x = k; e.y = l; e.tag = tag;
          ext(k, ww, sw, stx, nx, dx, e.sx, e.l, e.r);
          ext(l, wh, sh, sty, ny, dy, e.sy, e.t, e.b);
          q.push_back(e);
        end
        n++;
      end
    end
  endtask

  task automatic drive_cfg();
    tgt_w_i = CW'(cw); tgt_h_i = CW'(ch);
    win_w_i = WW'(ww); win_h_i = WW'(wh);
    src_w_i = SW'(sw); src_h_i = SW'(sh);
    reg_step_x_i = CW'(stx); reg_num_x_i = CW'(nx); reg_dn_x_i = dx[0];
    reg_step_y_i = CW'(sty); reg_num_y_i = CW'(ny); reg_dn_y_i = dy[0];
  endtask

  // called just after a falling edge
  task automatic launch(int npix, string tag);
    push_frame(npix, tag);
    drive_cfg();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (cw * ch + 4) @(negedge clk);
    #1;
    checks++;
    if (q.size() != 0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL %s drain: pending=%0d valid=%0b expected pending=0 valid=0",
               tag, q.size(), valid_o);
    end
    q.delete();
  endtask

  task automatic set_cfg(int a_cw, int a_ch, int a_ww, int a_wh, int a_sw, int a_sh,
                         int a_stx, int a_nx, int a_dx, int a_sty, int a_ny, int a_dy);
    cw = a_cw; ch = a_ch; ww = a_ww; wh = a_wh; sw = a_sw; sh = a_sh;
    stx = a_stx; nx = a_nx; dx = a_dx; sty = a_sty; ny = a_ny; dy = a_dy;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o === 1'b1 && !done) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result x=%0d y=%0d expected none", tgt_x_o, tgt_y_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (int'(tgt_x_o) != e.x || int'(tgt_y_o) != e.y ||
            int'(src_x_o) != e.sx || int'(src_y_o) != e.sy ||
            int'(ovl_l_o) != e.l || int'(ovl_r_o) != e.r ||
            int'(ovl_t_o) != e.t || int'(ovl_b_o) != e.b) begin
          errors++;
          $display("FAIL %s got (%0d,%0d) src(%0d,%0d) l=%0d r=%0d t=%0d b=%0d expected (%0d,%0d) src(%0d,%0d) l=%0d r=%0d t=%0d b=%0d",
                   e.tag, tgt_x_o, tgt_y_o, src_x_o, src_y_o, ovl_l_o, ovl_r_o, ovl_t_o, ovl_b_o,
                   e.x, e.y, e.sx, e.sy, e.l, e.r, e.t, e.b);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle during and after reset
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset valid=%0b expected 0", valid_o);
    end
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset valid=%0b expected 0", valid_o);
    end

    // R2 R3 R4 R5: window equal to source pixel
    set_cfg(4, 3, 4, 4, 4, 4, 0, 0, 0, 0, 0, 0);
    launch(cw * ch, "R2/R3/R4/R5 unity");
    drain("R2 unity");

    // R3 R4 R5: enlargement with fractional coverage
    set_cfg(6, 5, 2, 2, 3, 5, 0, 0, 0, 0, 0, 0);
    launch(cw * ch, "R3/R4/R5 enlarge");
    drain("R2 enlarge");

    // R6: overlapping regulation, shift left
    set_cfg(9, 2, 2, 2, 3, 3, 3, 2, 1, 0, 0, 0);
    launch(cw * ch, "R6 shift-left");
    drain("R2 shift-left");

    // R6: inserting regulation with a two-column source jump (R5)
    set_cfg(8, 2, 2, 3, 2, 3, 2, 3, 0, 0, 0, 0);
    launch(cw * ch, "R6/R5 insert-jump");
    drain("R2 insert-jump");

    // R7: vertical regulation both directions
    set_cfg(3, 7, 2, 2, 3, 3, 0, 0, 0, 2, 2, 1);
    launch(cw * ch, "R7 up");
    drain("R2 up");
    set_cfg(2, 6, 3, 3, 3, 4, 0, 0, 0, 1, 2, 0);
    launch(cw * ch, "R7 down");
    drain("R2 down");

    // R8: configuration changes mid-frame are ignored
    set_cfg(5, 4, 2, 2, 3, 3, 2, 1, 1, 0, 0, 0);
    launch(cw * ch, "R8 frozen-config");
    repeat (2) @(negedge clk);
    tgt_w_i = CW'(2); tgt_h_i = CW'(9); win_w_i = WW'(1); src_w_i = SW'(7);
    reg_step_x_i = CW'(1); reg_num_x_i = CW'(5); reg_dn_x_i = 1'b0; src_h_i = SW'(9);
    drain("R8 frozen-config");

    // R9: restart after 7 results of a first frame
    set_cfg(5, 4, 2, 2, 3, 3, 0, 0, 0, 0, 0, 0);
    launch(7, "R9 first");
    repeat (6) @(negedge clk);
    set_cfg(4, 2, 3, 2, 4, 5, 2, 1, 1, 0, 0, 0);
    launch(cw * ch, "R9 restarted");
    drain("R9 restarted");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule